// File: doc/BRIEF.md
# Chip-Select Window Decoder

The block decides which of several flash chip selects a host access belongs to. Each chip select has one 64-bit window register. The register holds an enable bit, a flag that marks the attached part as NAND or NOR, and a flag that marks the window as memory-mapped or I/O-mapped. It also holds a base and a mask. The space flag decides where the base and mask sit in the register: an I/O window compares address bits 15:4, and a memory window compares address bits 31:12.

Host accesses arrive on a valid/ready stream that carries the address and the space type. For each access the block returns one result beat on a second valid/ready stream. The result holds a one-hot select, a hit flag, the NAND flag of the winning window and the echoed space type. Software programs the window registers and reads them back through a plain indexed register port.

Back-pressure: the block accepts an access only when its single result slot is empty or is being drained in the same cycle (`acc_ready = !res_valid || res_ready`). A result that is not taken stays unchanged until `res_ready` is seen high.

Top module: `csel_window_decoder`

## Requirements
- R1: After reset every window register reads as zero, `res_valid` is low, and every window is disabled, so any access misses.
- R2: A write with `cfg_wr_en` high stores all 64 bits of `cfg_wdata` into the register chosen by `cfg_idx` at the clock edge. `cfg_rdata` shows the chosen register combinationally, and each register is independent of the others.
- R3: A window with bit 32 clear never matches, whatever its base and mask hold.
- R4: Bit 34 set makes a window memory-mapped, and such a window matches only accesses with `acc_mem` = 1. Bit 34 clear makes it I/O-mapped, and such a window matches only accesses with `acc_mem` = 0.
- R5: An I/O window takes its base from bits 15:4 and its mask from bits 47:36. It matches when `(acc_addr[15:4] & mask) == (base & mask)`; address bits 31:16 and 3:0 have no effect.
- R6: A memory window takes its base from bits 31:12 and its mask from bits 63:44. It matches when `(acc_addr[31:12] & mask) == (base & mask)`; address bits 11:0 have no effect.
- R7: When several windows match, the lowest-numbered one wins. `res_cs` has exactly one bit set (bit i for window i) on a hit and is zero on a miss.
- R8: `res_nand` carries bit 33 of the winning window (1 = NAND, 0 = NOR) and is 0 on a miss. `res_hit` is high exactly when `res_cs` is nonzero.
- R9: A result appears on the cycle after its access is accepted. The decode uses the register contents in force before any write made at the same edge.
- R10: While `res_valid` is high and `res_ready` is low, the result holds stable and `acc_ready` is low.
- R11: While `res_valid` is low, `res_cs`, `res_hit`, `res_nand` and `res_mem` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wr_en | input | 1 | Write strobe for the window register port |
| cfg_idx | input | IDX_W (2) | Window register index |
| cfg_wdata | input | 64 | Write data |
| cfg_rdata | output | 64 | Contents of the indexed register |
| acc_valid | input | 1 | Access beat valid |
| acc_ready | output | 1 | Access beat accepted when high with valid |
| acc_addr | input | ADDR_W (32) | Access address |
| acc_mem | input | 1 | 1 = memory access, 0 = I/O access |
| res_valid | output | 1 | Result beat valid |
| res_ready | input | 1 | Downstream takes the result |
| res_hit | output | 1 | Some window matched |
| res_cs | output | NUM_CS (4) | One-hot chip select of the winner |
| res_nand | output | 1 | Winner is NAND |
| res_mem | output | 1 | Echo of the access space |

## Verification
Some properties are checked on every cycle. These are the handshake rules: one-cycle latency after acceptance, a stable result and a closed input while stalled, and zero outputs while idle. They also cover the shape of the result: at most one select bit, hit agreeing with the select, and no NAND flag without a hit. Which window wins depends on the programmed registers, so the window arithmetic is shown only by the bench's scenarios. These sweep every I/O compare key and a wide set of memory keys, in both spaces, against overlapping, disabled and catch-all windows. Two more effects are also left to directed scenarios: a register write landing in the same cycle as an access, and a result held under back-pressure.

// File: rtl/csdec_pkg.sv
package csdec_pkg;

  localparam int REG_W        = 64;
  localparam int EN_BIT       = 32;
  localparam int NAND_BIT     = 33;
  localparam int MEM_BIT      = 34;

  localparam int IO_BASE_LO   = 4;
  localparam int IO_FIELD_W   = 12;
  localparam int IO_MASK_LO   = 36;

  localparam int MEM_BASE_LO  = 12;
  localparam int MEM_FIELD_W  = 20;
  localparam int MEM_MASK_LO  = 44;

  // widest compare field; I/O fields are zero-extended into it
  localparam int KEY_W = (MEM_FIELD_W > IO_FIELD_W) ? MEM_FIELD_W : IO_FIELD_W;

  typedef struct packed {
    logic             en;
    logic             nand_part;
    logic             mem_space;
    logic [KEY_W-1:0] base;
    logic [KEY_W-1:0] mask;
  } win_t;

  function automatic win_t unpack_win(input logic [REG_W-1:0] r);
    win_t w;
    w.en        = r[EN_BIT];
    w.nand_part = r[NAND_BIT];
    w.mem_space = r[MEM_BIT];
    w.base      = '0;
    w.mask      = '0;
    if (r[MEM_BIT]) begin
      w.base[MEM_FIELD_W-1:0] = r[MEM_BASE_LO +: MEM_FIELD_W];
      w.mask[MEM_FIELD_W-1:0] = r[MEM_MASK_LO +: MEM_FIELD_W];
    end else begin
      w.base[IO_FIELD_W-1:0]  = r[IO_BASE_LO +: IO_FIELD_W];
      w.mask[IO_FIELD_W-1:0]  = r[IO_MASK_LO +: IO_FIELD_W];
    end
    return w;
  endfunction

endpackage

// File: rtl/csdec_cfg_bank.sv
module csdec_cfg_bank #(
  parameter int NUM_CS = 4,
  parameter int IDX_W  = 2
) (
  input  logic                                  clk,
  input  logic                                  rst_n,
  input  logic                                  wr_en,
  input  logic [IDX_W-1:0]                      idx,
  input  logic [csdec_pkg::REG_W-1:0]           wdata,
  output logic [csdec_pkg::REG_W-1:0]           rdata,
  output logic [NUM_CS-1:0][csdec_pkg::REG_W-1:0] regs_q
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      regs_q <= '0;
    end else if (wr_en && (int'(idx) < NUM_CS)) begin
      regs_q[idx] <= wdata;
    end
  end

  always_comb begin
    rdata = '0;
    if (int'(idx) < NUM_CS) rdata = regs_q[idx];
  end

endmodule

// File: rtl/csdec_win_match.sv
module csdec_win_match #(
  parameter int ADDR_W = 32
) (
  input  logic [csdec_pkg::REG_W-1:0] win_reg,
  input  logic [ADDR_W-1:0]           addr,
  input  logic                        is_mem,
  output logic                        hit,
  output logic                        nand_part
);
  import csdec_pkg::*;

  win_t             w;
  logic [KEY_W-1:0] key;

  always_comb begin
    w   = unpack_win(win_reg);
    key = '0;
    if (is_mem) key[MEM_FIELD_W-1:0] = addr[MEM_BASE_LO +: MEM_FIELD_W];
    else        key[IO_FIELD_W-1:0]  = addr[IO_BASE_LO +: IO_FIELD_W];
    hit = w.en && (w.mem_space == is_mem) &&
          ((key & w.mask) == (w.base & w.mask));
    nand_part = w.nand_part;
  end

endmodule

// File: rtl/csdec_first_hit.sv
module csdec_first_hit #(
  parameter int N = 4
) (
  input  logic [N-1:0] req,
  output logic [N-1:0] grant,
  output logic         any
);

  always_comb begin
    grant = '0;
    any   = 1'b0;
    for (int i = 0; i < N; i++) begin
      if (req[i] && !any) begin
        grant[i] = 1'b1;
        any      = 1'b1;
      end
    end
  end

endmodule

// File: rtl/csel_window_decoder.sv
module csel_window_decoder #(
  parameter int NUM_CS = 4,
  parameter int ADDR_W = 32,
  localparam int IDX_W = (NUM_CS > 1) ? $clog2(NUM_CS) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_wr_en,
  input  logic [IDX_W-1:0]  cfg_idx,
  input  logic [63:0]       cfg_wdata,
  output logic [63:0]       cfg_rdata,
  input  logic              acc_valid,
  output logic              acc_ready,
  input  logic [ADDR_W-1:0] acc_addr,
  input  logic              acc_mem,
  output logic              res_valid,
  input  logic              res_ready,
  output logic              res_hit,
  output logic [NUM_CS-1:0] res_cs,
  output logic              res_nand,
  output logic              res_mem
);
  import csdec_pkg::*;

  logic [NUM_CS-1:0][REG_W-1:0] win_regs;
  logic [NUM_CS-1:0]            win_hit;
  logic [NUM_CS-1:0]            win_nand;
  logic [NUM_CS-1:0]            grant;
  logic                         any_hit;
  logic                         take_acc;

  csdec_cfg_bank #(.NUM_CS(NUM_CS), .IDX_W(IDX_W)) u_bank (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_en  (cfg_wr_en),
    .idx    (cfg_idx),
    .wdata  (cfg_wdata),
    .rdata  (cfg_rdata),
    .regs_q (win_regs)
  );

  for (genvar g = 0; g < NUM_CS; g++) begin : g_win
    csdec_win_match #(.ADDR_W(ADDR_W)) u_match (
      .win_reg   (win_regs[g]),
      .addr      (acc_addr),
      .is_mem    (acc_mem),
      .hit       (win_hit[g]),
      .nand_part (win_nand[g])
    );
  end

  csdec_first_hit #(.N(NUM_CS)) u_pick (
    .req   (win_hit),
    .grant (grant),
    .any   (any_hit)
  );

  assign acc_ready = !res_valid || res_ready;
  assign take_acc  = acc_valid && acc_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_valid <= 1'b0;
      res_hit   <= 1'b0;
      res_cs    <= '0;
      res_nand  <= 1'b0;
      res_mem   <= 1'b0;
    end else if (take_acc) begin
      res_valid <= 1'b1;
      res_hit   <= any_hit;
      res_cs    <= grant;
      res_nand  <= |(grant & win_nand);
      res_mem   <= acc_mem;
    end else if (res_ready) begin
      res_valid <= 1'b0;
      res_hit   <= 1'b0;
      res_cs    <= '0;
      res_nand  <= 1'b0;
      res_mem   <= 1'b0;
    end
  end

endmodule

// File: rtl/csdec_checker.sv
module csdec_checker #(
  parameter int NUM_CS = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              acc_valid,
  input logic              acc_ready,
  input logic              res_valid,
  input logic              res_ready,
  input logic              res_hit,
  input logic [NUM_CS-1:0] res_cs,
  input logic              res_nand,
  input logic              res_mem
);

  a_r7_single_select: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(res_cs));

  a_r8_hit_matches_select: assert property (@(posedge clk) disable iff (!rst_n)
    res_hit == (res_cs != '0));

  a_r8_no_nand_on_miss: assert property (@(posedge clk) disable iff (!rst_n)
    !res_hit |-> !res_nand);

  a_r9_one_cycle_result: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && acc_ready) |=> res_valid);

  a_r10_input_closed: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !res_ready) |-> !acc_ready);

  a_r10_hold_result: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !res_ready) |=>
      (res_valid && $stable(res_cs) && $stable(res_hit) &&
       $stable(res_nand) && $stable(res_mem)));

  a_r11_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !res_valid |-> (res_cs == '0 && !res_hit && !res_nand && !res_mem));

endmodule

bind csel_window_decoder csdec_checker #(.NUM_CS(NUM_CS)) u_csdec_checker (
  .clk       (clk),
  .rst_n     (rst_n),
  .acc_valid (acc_valid),
  .acc_ready (acc_ready),
  .res_valid (res_valid),
  .res_ready (res_ready),
  .res_hit   (res_hit),
  .res_cs    (res_cs),
  .res_nand  (res_nand),
  .res_mem   (res_mem)
);

// File: tb/csel_window_decoder_test.sv
module csel_window_decoder_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_wr_en = 1'b0;
  logic [1:0]  cfg_idx = '0;
  logic [63:0] cfg_wdata = '0;
  logic [63:0] cfg_rdata;
  logic        acc_valid = 1'b0;
  logic        acc_ready;
  logic [31:0] acc_addr = '0;
  logic        acc_mem = 1'b0;
  logic        res_valid;
  logic        res_ready = 1'b1;
  logic        res_hit;
  logic [3:0]  res_cs;
  logic        res_nand;
  logic        res_mem;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  logic [63:0] shadow [4];

  always #5 clk = ~clk;

  csel_window_decoder uut (
    .clk(clk), .rst_n(rst_n),
    .cfg_wr_en(cfg_wr_en), .cfg_idx(cfg_idx), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
    .acc_valid(acc_valid), .acc_ready(acc_ready), .acc_addr(acc_addr), .acc_mem(acc_mem),
    .res_valid(res_valid), .res_ready(res_ready), .res_hit(res_hit), .res_cs(res_cs),
    .res_nand(res_nand), .res_mem(res_mem)
  );

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [63:0] mk_io(input bit en, input bit nd,
                                        input logic [11:0] base, input logic [11:0] mask);
    logic [63:0] r = '0;
    r[32] = en; r[33] = nd; r[34] = 1'b0;
    r[15:4] = base; r[47:36] = mask;
    return r;
  endfunction

  function automatic logic [63:0] mk_mem(input bit en, input bit nd,
                                         input logic [19:0] base, input logic [19:0] mask);
    logic [63:0] r = '0;
    r[32] = en; r[33] = nd; r[34] = 1'b1;
    r[31:12] = base; r[63:44] = mask;
    return r;
  endfunction

  // expected {valid, hit, nand, mem, cs[3:0]} from the shadow registers
  function automatic logic [7:0] model(input logic [31:0] a, input bit m);
    logic [3:0] cs = '0;
    bit nd = 1'b0;
    bit found = 1'b0;
    for (int i = 0; i < 4; i++) begin
      logic [63:0] r = shadow[i];
      bit match;
      if (m) match = ((a[31:12] & r[63:44]) == (r[31:12] & r[63:44]));
      else   match = ((a[15:4]  & r[47:36]) == (r[15:4]  & r[47:36]));
      if (!found && r[32] && (r[34] == m) && match) begin
        found = 1'b1; cs[i] = 1'b1; nd = r[33];
      end
    end
    return {1'b1, found, nd, m, cs};
  endfunction

  function automatic logic [7:0] observed();
    return {res_valid, res_hit, res_nand, res_mem, res_cs};
  endfunction

  // called at a falling edge; returns at the next falling edge
  task automatic wr_reg(input int idx, input logic [63:0] val);
    cfg_wr_en = 1'b1; cfg_idx = 2'(idx); cfg_wdata = val;
    @(posedge clk); @(negedge clk);
    cfg_wr_en = 1'b0;
    shadow[idx] = val;
  endtask

  task automatic do_access(input string tag, input logic [31:0] a, input bit m);
    logic [7:0] exp;
    exp = model(a, m);
    acc_valid = 1'b1; acc_addr = a; acc_mem = m; res_ready = 1'b1;
    @(posedge clk); @(negedge clk);
    acc_valid = 1'b0;
    chk(tag, 64'(observed()), 64'(exp));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [7:0] exp_a, exp_b;
    for (int i = 0; i < 4; i++) shadow[i] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: reset state
    for (int i = 0; i < 4; i++) begin
      cfg_idx = 2'(i); #1;
      chk("R1 reg reset", cfg_rdata, 64'h0);
    end
    chk("R1 idle output", 64'({res_valid, res_hit, res_cs}), 64'h0);
    @(negedge clk);
    do_access("R1 all disabled mem", 32'h1234_5000, 1'b1);
    do_access("R1 all disabled io", 32'h0000_0120, 1'b0);

    // R2: full-width write and independent readback
    for (int i = 0; i < 4; i++)
      wr_reg(i, 64'h0123_4567_89AB_CDEF ^ {16{4'(i)}} ^ (64'h1 << (i * 13)));
    for (int i = 0; i < 4; i++) begin
      cfg_idx = 2'(i); #1;
      chk("R2 readback", cfg_rdata, shadow[i]);
    end
    @(negedge clk);

    // I/O configuration
    wr_reg(0, mk_io(1'b1, 1'b1, 12'h123, 12'hFFF));
    wr_reg(1, mk_io(1'b1, 1'b0, 12'h120, 12'hFF0));
    wr_reg(2, mk_io(1'b0, 1'b1, 12'h300, 12'hF00));
    wr_reg(3, mk_mem(1'b1, 1'b0, 20'h0, 20'h0));
    do_access("R3 disabled window ignored", 32'h0000_3450, 1'b0);
    do_access("R7 lowest index wins", 32'h0000_1230, 1'b0);
    do_access("R8 nand flag of winner", 32'h0000_1238, 1'b0);
    do_access("R8 nor flag of winner", 32'h0000_1250, 1'b0);
    do_access("R4 io access skips mem window", 32'h0000_0000, 1'b0);
    do_access("R4 mem access hits mem window", 32'h0000_1230, 1'b1);
    do_access("R5 upper and low bits ignored", 32'hFFFF_123F, 1'b0);
    for (int i = 0; i < 4096; i++)
      do_access("R5 io sweep", {i[3:0], 12'hA5C, i[11:0], i[3:0] ^ 4'h9}, 1'b0);

    // memory configuration
    wr_reg(0, mk_mem(1'b1, 1'b0, 20'h80012, 20'hFFFFF));
    wr_reg(1, mk_mem(1'b1, 1'b1, 20'h80000, 20'hFFF00));
    wr_reg(2, mk_io(1'b1, 1'b1, 12'h000, 12'h000));
    wr_reg(3, mk_mem(1'b1, 1'b0, 20'h55555, 20'h00000));
    do_access("R7 mem overlap lowest wins", 32'h8001_2ABC, 1'b1);
    do_access("R8 mem nand window", 32'h8001_3000, 1'b1);
    do_access("R6 low bits ignored", 32'h800F_FFFF, 1'b1);
    do_access("R6 outside window to catch-all", 32'h8010_0000, 1'b1);
    do_access("R4 io catch-all", 32'h8001_2000, 1'b0);
    for (int i = 0; i < 4096; i++) begin
      do_access("R6 mem sweep", {i[11:0], i[7:0], 12'(i * 7)}, 1'b1);
      do_access("R4 space sweep", {i[11:0], i[7:0], 12'(i * 7)}, 1'b0);
    end

    // R9: write in the same cycle as an access uses the old contents
    wr_reg(2, mk_io(1'b0, 1'b0, 12'h0, 12'h0));
    wr_reg(0, mk_io(1'b1, 1'b1, 12'h123, 12'hFFF));
    wr_reg(1, mk_io(1'b1, 1'b0, 12'h120, 12'hFF0));
    exp_a = model(32'h0000_1230, 1'b0);
    cfg_wr_en = 1'b1; cfg_idx = 2'd0; cfg_wdata = 64'h0;
    acc_valid = 1'b1; acc_addr = 32'h0000_1230; acc_mem = 1'b0;
    @(posedge clk); @(negedge clk);
    cfg_wr_en = 1'b0; acc_valid = 1'b0; shadow[0] = 64'h0;
    chk("R9 old contents used", 64'(observed()), 64'(exp_a));
    do_access("R9 new contents next access", 32'h0000_1230, 1'b0);

    // R10: back-pressure
    exp_a = model(32'h0000_1230, 1'b0);
    exp_b = model(32'h1234_0000, 1'b1);
    res_ready = 1'b0; acc_valid = 1'b1; acc_addr = 32'h0000_1230; acc_mem = 1'b0;
    @(posedge clk); @(negedge clk);
    chk("R9 result after one cycle", 64'(observed()), 64'(exp_a));
    chk("R10 input closed when stalled", 64'(acc_ready), 64'h0);
    acc_addr = 32'h1234_0000; acc_mem = 1'b1;
    for (int k = 0; k < 3; k++) begin
      @(posedge clk); @(negedge clk);
      chk("R10 result held", 64'(observed()), 64'(exp_a));
    end
    res_ready = 1'b1;
    @(posedge clk); @(negedge clk);
    acc_valid = 1'b0;
    chk("R10 second access after drain", 64'(observed()), 64'(exp_b));
    @(posedge clk); @(negedge clk);
    chk("R11 idle outputs zero", 64'(observed()), 64'h0);

    done = 1'b1;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule